// File: doc/BRIEF.md
# Bit-Serial Control Latch

This block holds a 20-bit word of board controls that a host loads one bit at a time over three slow lines: a serial data line, a shift clock and a load strobe. All three lines are brought into the system clock domain through two-flop synchronisers, and their rising edges are detected there. Each rising edge of the shift clock moves the current data bit into a shift register, least significant bit first. A rising edge on the load strobe copies the whole shift register into the output register in one step. The output register drives the controls, so the outputs never show a word that is only partly shifted in.

The output word mixes fifteen single-bit controls, several of them active low, with a 2-bit source select for digital output 0 and a 3-bit source select for digital output 1. On reset the output register takes a safe value. The active-low selects and the LED line are driven high (inactive). Both mutes are asserted and the ADC is held in reset. The selectors are zero.

Top module: `ser_ctl_latch`

## Requirements
- R1: After reset, ctl_word_o is 0x04045: bits 0, 2, 6 and 14 are 1 and all other bits are 0, so both mutes (bits 9 and 13) and the ADC reset (bit 11) are active (low).
- R2: Bits are taken least significant bit first. After exactly 20 shifts and a load, the first bit shifted in appears at ctl_word_o[0] and the last one at ctl_word_o[19].
- R3: The data line is sampled at the rising edge of the shift clock. A change on the data line while the shift clock stays high has no effect on the captured bit.
- R4: ctl_word_o keeps its value while bits are being shifted and changes only after a load.
- R5: Each rising edge of the load strobe transfers the shift register once. While the load strobe stays high, shifts that follow do not reach the outputs until the next rising edge of the load strobe.
- R6: single_ctl_o equals ctl_word_o[14:0], dout0_sel_o equals ctl_word_o[16:15], and dout1_sel_o equals ctl_word_o[19:17].
- R7: When more than 20 bits are shifted before a load, only the last 20 bits shifted are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sdata_i | input | 1 | Serial data line from the host, asynchronous |
| sclk_i | input | 1 | Shift clock from the host, asynchronous |
| load_i | input | 1 | Load strobe from the host, asynchronous, active high |
| ctl_word_o | output | 20 | Full output control word |
| single_ctl_o | output | 15 | Single-bit board controls (word bits 14:0) |
| dout0_sel_o | output | 2 | Digital output 0 source select (word bits 16:15) |
| dout1_sel_o | output | 3 | Digital output 1 source select (word bits 19:17) |

## Verification
The bench shifts a single one in as the first bit and then as the last bit. This shows whether the bit order is reversed. Random words are shifted in, with the outputs compared against the previous word before the load, which tells a latch that updates too early from a correct one. The random words also separate the three field slices. The bench also flips the data line while the shift clock is high, shifts more than 20 bits, and shifts while the load strobe is held high. These show whether sampling happens on the rising edge, whether the oldest bits are dropped, and whether a load acts on its edge or on its level.

// File: rtl/ser_ctl_pkg.sv
package ser_ctl_pkg;
  localparam int unsigned WORD_W  = 20;
  localparam int unsigned SINGLE_W = 15;
  localparam int unsigned SEL0_W  = 2;
  localparam int unsigned SEL1_W  = 3;
  localparam int unsigned SEL0_LO = SINGLE_W;
  localparam int unsigned SEL1_LO = SEL0_LO + SEL0_W;

  // single-bit control positions whose behaviour the reset value depends on
  localparam int unsigned B_AC3_SEL_N  = 0;
  localparam int unsigned B_ROM_CTL_N  = 2;
  localparam int unsigned B_TRIM_CS_N  = 6;
  localparam int unsigned B_TRIM_MUTE_N = 9;
  localparam int unsigned B_ADC_RST_N  = 11;
  localparam int unsigned B_DAC_MUTE_N = 13;
  localparam int unsigned B_LED_N      = 14;

  // safe default: selects off, LED off, mutes on, ADC held in reset
  localparam logic [WORD_W-1:0] RST_WORD =
      (WORD_W'(1) << B_AC3_SEL_N) | (WORD_W'(1) << B_ROM_CTL_N) |
      (WORD_W'(1) << B_TRIM_CS_N) | (WORD_W'(1) << B_LED_N);
endpackage

// File: rtl/ser_sync_edge.sv
module ser_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic level_o,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign level_o = sync_q[STAGES-1];
  assign rise_o  = sync_q[STAGES-1] & ~prev_q;

  p_rise_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/ser_shift_reg.sv
module ser_shift_reg #(
  parameter int unsigned WIDTH = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shift_i,
  input  logic             bit_i,
  output logic [WIDTH-1:0] word_o
);
  logic [WIDTH-1:0] sr_q;

  // LSB first: new bits enter at the top and walk down
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (shift_i) sr_q <= {bit_i, sr_q[WIDTH-1:1]};
  end

  assign word_o = sr_q;

  p_new_bit_top_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |=> sr_q[WIDTH-1] == $past(bit_i));
  p_drop_oldest_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |=> sr_q[WIDTH-2:0] == $past(sr_q[WIDTH-1:1]));
endmodule

// File: rtl/ser_out_reg.sv
module ser_out_reg #(
  parameter int unsigned        WIDTH = 20,
  parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] next_i,
  output logic [WIDTH-1:0] word_o
);
  logic [WIDTH-1:0] word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     word_q <= RST_VAL;
    else if (load_i) word_q <= next_i;
  end

  assign word_o = word_q;

  p_hold_no_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(word_q));
  p_load_copies_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> word_q == $past(next_i));
endmodule

// File: rtl/ser_ctl_latch.sv
module ser_ctl_latch
  import ser_ctl_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sdata_i,
  input  logic                sclk_i,
  input  logic                load_i,
  output logic [WORD_W-1:0]   ctl_word_o,
  output logic [SINGLE_W-1:0] single_ctl_o,
  output logic [SEL0_W-1:0]   dout0_sel_o,
  output logic [SEL1_W-1:0]   dout1_sel_o
);
  localparam int unsigned N_IN = 3;
  localparam int unsigned I_DAT = 0;
  localparam int unsigned I_CLK = 1;
  localparam int unsigned I_LD  = 2;

  logic [N_IN-1:0]   in_raw, in_lvl, in_rise;
  logic [WORD_W-1:0] shift_word, out_word;

  assign in_raw = {load_i, sclk_i, sdata_i};

  for (genvar g = 0; g < N_IN; g++) begin : g_sync
    ser_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .async_i (in_raw[g]),
      .level_o (in_lvl[g]),
      .rise_o  (in_rise[g])
    );
  end

  ser_shift_reg #(.WIDTH(WORD_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (in_rise[I_CLK]),
    .bit_i   (in_lvl[I_DAT]),
    .word_o  (shift_word)
  );

  ser_out_reg #(.WIDTH(WORD_W), .RST_VAL(RST_WORD)) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (in_rise[I_LD]),
    .next_i (shift_word),
    .word_o (out_word)
  );

  assign ctl_word_o   = out_word;
  assign single_ctl_o = out_word[SINGLE_W-1:0];
  assign dout0_sel_o  = out_word[SEL0_LO +: SEL0_W];
  assign dout1_sel_o  = out_word[SEL1_LO +: SEL1_W];

  p_reset_safe_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> ctl_word_o == RST_WORD);
endmodule

// File: tb/ser_ctl_latch_tb.sv
module ser_ctl_latch_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sdata = 1'b0, sclk = 1'b0, load = 1'b0;
  logic [19:0] word;
  logic [14:0] single;
  logic [1:0]  sel0;
  logic [2:0]  sel1;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  ser_ctl_latch dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sdata_i(sdata), .sclk_i(sclk), .load_i(load),
    .ctl_word_o(word), .single_ctl_o(single), .dout0_sel_o(sel0), .dout1_sel_o(sel1)
  );

  task automatic chk(input string req, input logic [19:0] got, input logic [19:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%05h expected 0x%05h", req, got, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic shift_bit(input logic b, input bit flip_high);
    sdata = b;
    wait_n(3);
    sclk = 1'b1;
    wait_n(4);
    if (flip_high) sdata = ~b;
    wait_n(2);
    sclk = 1'b0;
    wait_n(4);
  endtask

  task automatic shift_word(input logic [19:0] w, input bit flip_high);
    for (int i = 0; i < 20; i++) shift_bit(w[i], flip_high);
  endtask

  task automatic pulse_load();
    load = 1'b1;
    wait_n(4);
    load = 1'b0;
    wait_n(4);
  endtask

  task automatic t_reset();
    chk("R1 reset word", word, 20'h04045);
    chk("R6 reset sel", {15'd0, sel1, sel0}, 20'd0);
  endtask

  task automatic t_lsb_first();
    shift_word(20'h00001, 1'b0);
    pulse_load();
    chk("R2 first bit lands at 0", word, 20'h00001);
    shift_word(20'h80000, 1'b0);
    pulse_load();
    chk("R2 last bit lands at 19", word, 20'h80000);
  endtask

  task automatic t_random_fields();
    logic [19:0] prev, w;
    for (int k = 0; k < 6; k++) begin
      prev = word;
      w = 20'($urandom());
      shift_word(w, 1'b0);
      chk("R4 hold before load", word, prev);
      pulse_load();
      chk("R4 word after load", word, w);
      chk("R6 single field", {5'd0, single}, {5'd0, w[14:0]});
      chk("R6 sel0 field", {18'd0, sel0}, {18'd0, w[16:15]});
      chk("R6 sel1 field", {17'd0, sel1}, {17'd0, w[19:17]});
    end
  endtask

  task automatic t_rise_sample();
    shift_word(20'hA5C3E, 1'b1);
    pulse_load();
    chk("R3 sampled at shift clock rise", word, 20'hA5C3E);
  endtask

  task automatic t_overflow();
    shift_word(20'h12345, 1'b0);
    for (int i = 0; i < 5; i++) shift_bit(1'b1, 1'b0);
    pulse_load();
    chk("R7 last 20 bits kept", word, 20'hF891A);
  endtask

  task automatic t_load_held();
    shift_word(20'h0F0F0, 1'b0);
    load = 1'b1;
    wait_n(5);
    chk("R5 load edge transfers", word, 20'h0F0F0);
    shift_word(20'h3C3C3, 1'b0);
    chk("R5 held load ignores later shifts", word, 20'h0F0F0);
    load = 1'b0;
    wait_n(4);
    pulse_load();
    chk("R5 next load edge transfers", word, 20'h3C3C3);
  endtask

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(2);
    t_reset();
    t_lsb_first();
    t_random_fields();
    t_rise_sample();
    t_overflow();
    t_load_held();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule